// File: doc/BRIEF.md
# Packet Timestamp Capture Buffer

This block records the current value of a 64-bit time counter when a packet classifier signals an event packet. It keeps one buffer for the receive direction and one for the transmit direction. Each buffer holds a single capture: the time and a 16-bit sequence identifier taken from the packet. Software collects the capture through a small word-addressed register port. It first reads a status word that carries a valid flag. It then reads the low and high halves of the time. Finally it writes a 1 to the valid bit, which frees the buffer for the next event.

The first event wins. While a buffer holds an uncollected capture, later strobes leave the stored time and identifier unchanged. Each such strobe only advances a saturating count of lost events, which software can read. A control word enables each direction on its own, and a disabled direction ignores its strobes. Software is expected to clear any old capture when it turns the feature on and whenever the classifier rules change.

Top module: `tscap_top`

## Requirements
- R1: After synchronous reset every register reads 0. Both valid flags are clear, both overflow counts are 0 and both directions are disabled.
- R2: A strobe on an enabled direction whose valid flag is clear stores that cycle's `time_now` and sequence input, and sets the valid flag. Status bit 16 is valid and bits 15:0 hold the sequence. The low time word holds time bits 31:0 and the high word holds bits 63:32.
- R3: While a direction's valid flag is set, further strobes leave its stored time and sequence unchanged.
- R4: Each strobe ignored under R3 adds 1 to that direction's overflow count in status bits 31:24. The count saturates at 255.
- R5: Writing a status word with bit 16 set clears that direction's valid flag and its overflow count. Writing a status word with bit 16 clear, or writing to a time word, changes nothing.
- R6: If a strobe and a clearing write reach the same direction in the same cycle, the new event is stored. The valid flag stays set and the overflow count becomes 0.
- R7: Control bit 0 enables receive and bit 1 enables transmit. A strobe on a disabled direction stores nothing and does not count as an overflow.
- R8: The two directions are independent. Strobes, clears and counts on one direction never change the other direction's registers.
- R9: Word addresses are: 0 control, 1 rx status, 2 rx time low, 3 rx time high, 5 tx status, 6 tx time low, 7 tx time high. Address 4 reads 0. `reg_rdata` shows the register at the address presented one cycle earlier, as it stood before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Running time counter value |
| rx_evt_stb | input | 1 | Receive event-packet strobe from classifier |
| rx_evt_seq | input | 16 | Sequence identifier of the receive event packet |
| tx_evt_stb | input | 1 | Transmit event-packet strobe from classifier |
| tx_evt_seq | input | 16 | Sequence identifier of the transmit event packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the previous cycle's address |

## Verification
A capture, clear or control write takes effect at the edge where it is presented. It becomes visible on `reg_rdata` one edge later, provided the read address is presented in the cycle after the stimulus. The bench's reference model is built on this timing. At each rising edge it first forms the expected read word from its own state as it stood before the edge, and only then applies strobes, clears and control writes using the enables from before the edge. The comparison happens on the falling edge, where the design's registered read word is stable. Every cycle is compared, including the cycles in which a strobe meets a clear.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    localparam int NDIR      = 2;
    localparam int REG_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int TIME_W    = 64;
    localparam int SEQ_W     = 16;
    localparam int OVF_W     = 8;
    localparam int VALID_BIT = 16;
    localparam int OVF_LSB   = 24;
    localparam int DIR_SPAN  = 4;

    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_STATUS = 2'd1,
        FLD_TS_LO  = 2'd2,
        FLD_TS_HI  = 2'd3
    } field_e;

    typedef struct packed {
        logic             valid;
        logic [OVF_W-1:0] ovf;
        logic [SEQ_W-1:0] seq;
        logic [TIME_W-1:0] stamp;
    } slot_t;

    function automatic logic [REG_W-1:0] status_word(slot_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[SEQ_W-1:0]         = s.seq;
        w[VALID_BIT]         = s.valid;
        w[OVF_LSB +: OVF_W]  = s.ovf;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] field_addr(int dir, field_e f);
        return ADDR_W'(dir * DIR_SPAN + int'(f));
    endfunction

endpackage

// File: rtl/tscap_slot.sv
module tscap_slot
    import tscap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              evt_stb,
    input  logic [SEQ_W-1:0]  evt_seq,
    input  logic [TIME_W-1:0] time_now,
    input  logic              clr,
    output logic [REG_W-1:0]  status,
    output logic [REG_W-1:0]  ts_lo,
    output logic [REG_W-1:0]  ts_hi
);

    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    slot_t st_q;
    logic  cap;

    assign cap = en & evt_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (cap && (!st_q.valid || clr)) begin
            st_q.valid <= 1'b1;
            st_q.stamp <= time_now;
            st_q.seq   <= evt_seq;
            st_q.ovf   <= '0;
        end else if (clr) begin
            st_q.valid <= 1'b0;
            st_q.ovf   <= '0;
        end else if (cap && st_q.ovf != OVF_MAX) begin
            st_q.ovf <= st_q.ovf + 1'b1;
        end
    end

    assign status = status_word(st_q);
    assign ts_lo  = st_q.stamp[REG_W-1:0];
    assign ts_hi  = st_q.stamp[TIME_W-1:REG_W];

    assert_first_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.valid && !clr) |=> ($stable(st_q.stamp) && $stable(st_q.seq) && st_q.valid));

    assert_ovf_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.ovf == OVF_MAX && !clr) |=> (st_q.ovf == OVF_MAX));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && !cap) |=> (!st_q.valid && st_q.ovf == '0));

    assert_cap_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && cap) |=> (st_q.valid && st_q.ovf == '0));

    assert_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> ($stable(st_q.valid) && $stable(st_q.ovf) && $stable(st_q.stamp)));

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (cap && !st_q.valid) |=> (st_q.valid && st_q.stamp == $past(time_now)));

endmodule

// File: rtl/tscap_regs.sv
module tscap_regs
    import tscap_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    input  logic [NDIR-1:0][REG_W-1:0]  status_in,
    input  logic [NDIR-1:0][REG_W-1:0]  lo_in,
    input  logic [NDIR-1:0][REG_W-1:0]  hi_in,
    output logic [NDIR-1:0]             en,
    output logic [NDIR-1:0]             clr,
    output logic [REG_W-1:0]            reg_rdata
);

    logic [NDIR-1:0]  en_q;
    logic [REG_W-1:0] rd_q;
    logic [REG_W-1:0] rd_next;
    field_e           fld;
    logic             dsel;

    assign fld  = field_e'(reg_addr[1:0]);
    assign dsel = reg_addr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (reg_wr && reg_addr == field_addr(0, FLD_CTRL)) begin
            en_q <= reg_wdata[NDIR-1:0];
        end
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_clr
        assign clr[d] = reg_wr && (reg_addr == field_addr(d, FLD_STATUS))
                        && reg_wdata[VALID_BIT];
    end

    always_comb begin
        rd_next = '0;
        case (fld)
            FLD_CTRL:   if (!dsel) rd_next[NDIR-1:0] = en_q;
            FLD_STATUS: rd_next = status_in[dsel];
            FLD_TS_LO:  rd_next = lo_in[dsel];
            FLD_TS_HI:  rd_next = hi_in[dsel];
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_next;
    end

    assign en        = en_q;
    assign reg_rdata = rd_q;

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(DIR_SPAN)) |=> (reg_rdata == '0));

    assert_clear_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));

endmodule

// File: rtl/tscap_top.sv
module tscap_top
    import tscap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       time_now,
    input  logic              rx_evt_stb,
    input  logic [15:0]       rx_evt_seq,
    input  logic              tx_evt_stb,
    input  logic [15:0]       tx_evt_seq,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic [NDIR-1:0]             stb_v;
    logic [NDIR-1:0][SEQ_W-1:0]  seq_v;
    logic [NDIR-1:0]             en_v;
    logic [NDIR-1:0]             clr_v;
    logic [NDIR-1:0][REG_W-1:0]  status_v;
    logic [NDIR-1:0][REG_W-1:0]  lo_v;
    logic [NDIR-1:0][REG_W-1:0]  hi_v;

    assign stb_v = {tx_evt_stb, rx_evt_stb};
    assign seq_v = {tx_evt_seq, rx_evt_seq};

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        tscap_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .en       (en_v[d]),
            .evt_stb  (stb_v[d]),
            .evt_seq  (seq_v[d]),
            .time_now (time_now),
            .clr      (clr_v[d]),
            .status   (status_v[d]),
            .ts_lo    (lo_v[d]),
            .ts_hi    (hi_v[d])
        );
    end

    tscap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_in (status_v),
        .lo_in     (lo_v),
        .hi_in     (hi_v),
        .en        (en_v),
        .clr       (clr_v),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/tscap_top_tb_top.sv
module tscap_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] time_now = 64'h0000_0001_FFFF_FF00;
    logic        rx_evt_stb = 1'b0;
    logic [15:0] rx_evt_seq = '0;
    logic        tx_evt_stb = 1'b0;
    logic [15:0] tx_evt_seq = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    tscap_top dut_i (
        .clk(clk), .rst(rst), .time_now(time_now),
        .rx_evt_stb(rx_evt_stb), .rx_evt_seq(rx_evt_seq),
        .tx_evt_stb(tx_evt_stb), .tx_evt_seq(tx_evt_seq),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) time_now <= time_now + 64'd7;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    bit              m_valid [2];
    int              m_ovf   [2];
    longint unsigned m_ts    [2];
    int              m_seq   [2];
    bit              m_en    [2];
    logic [31:0]     exp_rdata = '0;

    function automatic logic [31:0] model_read(logic [2:0] a);
        int d;
        d = a[2];
        case (a[1:0])
            2'd0: return (a[2] == 1'b0) ? {30'd0, m_en[1], m_en[0]} : 32'd0;
            2'd1: return {m_ovf[d][7:0], 7'd0, m_valid[d], m_seq[d][15:0]};
            2'd2: return m_ts[d][31:0];
            default: return m_ts[d][63:32];
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            exp_rdata = '0;
            for (int d = 0; d < 2; d++) begin
                m_valid[d] = 0; m_ovf[d] = 0; m_ts[d] = 0; m_seq[d] = 0; m_en[d] = 0;
            end
        end else begin
            bit stb [2];
            int sq  [2];
            exp_rdata = model_read(reg_addr);
            stb[0] = rx_evt_stb; stb[1] = tx_evt_stb;
            sq[0]  = rx_evt_seq; sq[1]  = tx_evt_seq;
            for (int d = 0; d < 2; d++) begin
                bit cap, clr;
                cap = m_en[d] && stb[d];
                clr = reg_wr && (reg_addr == 3'(d*4 + 1)) && reg_wdata[16];
                if (cap && (!m_valid[d] || clr)) begin
                    m_valid[d] = 1; m_ts[d] = time_now; m_seq[d] = sq[d]; m_ovf[d] = 0;
                end else if (clr) begin
                    m_valid[d] = 0; m_ovf[d] = 0;
                end else if (cap && m_ovf[d] < 255) begin
                    m_ovf[d]++;
                end
            end
            if (reg_wr && reg_addr == 3'd0) begin
                m_en[0] = reg_wdata[0]; m_en[1] = reg_wdata[1];
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp++;
            if (reg_rdata !== exp_rdata) begin
                n_bad++;
                $display("FAIL %s: reg_rdata actual %08h expected %08h (t=%0t)",
                         cur_req, reg_rdata, exp_rdata, $time);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: cycles actual %0d expected below %0d", cycles, WATCHDOG);
            report();
        end
    end

    task automatic cyc(input logic [2:0] a, input bit wr, input logic [31:0] wd,
                       input bit rs, input logic [15:0] rq, input bit ts, input logic [15:0] tq);
        reg_addr = a; reg_wr = wr; reg_wdata = wd;
        rx_evt_stb = rs; rx_evt_seq = rq; tx_evt_stb = ts; tx_evt_seq = tq;
        @(negedge clk);
        reg_wr = 0; rx_evt_stb = 0; tx_evt_stb = 0;
    endtask

    task automatic rd(input logic [2:0] a);
        cyc(a, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd_all();
        for (int a = 0; a < 8; a++) rd(3'(a));
        rd(3'd0);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 0;
        rd_all();

        // R7: strobes on disabled directions store and count nothing
        cur_req = "R7";
        cyc(3'd1, 0, 0, 1, 16'h1111, 1, 16'h2222);
        cyc(3'd5, 0, 0, 1, 16'h1111, 1, 16'h2222);
        rd_all();

        // R9: address map; control enables both directions
        cur_req = "R9";
        cyc(3'd0, 1, 32'h3, 0, 0, 0, 0);
        rd(3'd0); rd(3'd4);

        // R2: capture on each direction at distinct times
        cur_req = "R2";
        cyc(3'd1, 0, 0, 1, 16'h1234, 0, 0);
        rd(3'd1); rd(3'd2); rd(3'd3);
        repeat (40) rd(3'd2);
        cyc(3'd5, 0, 0, 0, 0, 1, 16'hBEEF);
        rd(3'd5); rd(3'd6); rd(3'd7);

        // R3 / R4: later strobes ignored but counted
        cur_req = "R3";
        for (int i = 0; i < 5; i++) cyc(3'd2, 0, 0, 1, 16'(16'h5000 + i), 0, 0);
        rd(3'd1); rd(3'd2); rd(3'd3);
        cur_req = "R4";
        rd(3'd1);

        // R5: write with bit 16 clear and to time words does nothing
        cur_req = "R5";
        cyc(3'd1, 1, 32'hFFFE_FFFF, 0, 0, 0, 0);
        cyc(3'd2, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        cyc(3'd3, 1, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(3'd1); rd(3'd2); rd(3'd3);
        cyc(3'd1, 1, 32'h0001_0000, 0, 0, 0, 0);
        rd(3'd1);

        // R8: tx untouched by rx clear; rx untouched by tx strobes
        cur_req = "R8";
        rd(3'd5); rd(3'd6); rd(3'd7);
        cyc(3'd1, 0, 0, 0, 0, 1, 16'h7777);
        rd(3'd1); rd(3'd5);

        // R6: capture and clear in the same cycle
        cur_req = "R6";
        cyc(3'd1, 0, 0, 1, 16'hAAAA, 0, 0);
        cyc(3'd1, 0, 0, 1, 16'hAAAB, 0, 0);
        rd(3'd1);
        cyc(3'd1, 1, 32'h0001_0000, 1, 16'hCAFE, 0, 0);
        rd(3'd1); rd(3'd2); rd(3'd3);

        // R4: saturation of tx overflow count
        cur_req = "R4";
        for (int i = 0; i < 300; i++) cyc(3'd5, 0, 0, 0, 0, 1, 16'(i));
        rd(3'd5); rd(3'd6);
        cyc(3'd5, 1, 32'h0001_0000, 0, 0, 0, 0);
        rd(3'd5);

        // R7: disable rx only, clear it, strobe it
        cur_req = "R7";
        cyc(3'd0, 1, 32'h2, 0, 0, 0, 0);
        cyc(3'd1, 1, 32'h0001_0000, 0, 0, 0, 0);
        cyc(3'd1, 0, 0, 1, 16'h4242, 1, 16'h4343);
        cyc(3'd1, 0, 0, 1, 16'h4242, 0, 0);
        rd(3'd1); rd(3'd2); rd(3'd5); rd(3'd6); rd(3'd0);

        // R1: reset in mid-run returns everything to zero
        cur_req = "R1";
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd_all();

        repeat (2) @(negedge clk);
        report();
    end

endmodule